// File: doc/BRIEF.md
# Prescaled Input Glitch Filter Bank

This block conditions a set of external interrupt inputs. Each line is first brought into the system clock domain through a two-flop synchroniser. It then goes through a digital glitch filter that accepts a new level only after that level has held for a programmed number of filter ticks. One programmable prescaler, shared by all lines, generates the filter ticks by dividing the system clock.

Each filtered level feeds an edge detector. The detector sets a sticky per-line pending flag on a rising or falling transition, for each polarity that is enabled. Software clears the flag through a write-1-to-clear strobe. A line that is not enabled for filtering, or that is programmed with a count of 0 to 2, passes its synchronised input straight to the output.

Top module: `irq_filter_bank`

## Requirements
- R1: Each input goes through two synchroniser flops and one output register, so in pass-through a level change at `pad_i` appears on `filt_o` after exactly 3 rising clock edges.
- R2: The shared prescaler produces one filter tick every `prescale_i`+1 clock cycles (4-bit setting, 0 to 15).
- R3: A line that is enabled and has a maximum count of 0, 1 or 2 behaves as an all-pass with the R1 latency.
- R4: A line whose enable bit is 0 passes its input through with the R1 latency, whatever its maximum count.
- R5: For a maximum count M from 3 to 15, a new level reaches `filt_o` no earlier than (M-1)(P+1)+3 and no later than M(P+1)+2 cycles after it is applied, where P is the prescaler setting.
- R6: The filter counter clears whenever the synchronised input equals the filtered output, so a pulse shorter than M ticks never reaches `filt_o`.
- R7: A change of `prescale_i` restarts the prescaler from zero. When the setting changes on the same edge at which the input is applied, with P≥1, the output follows after exactly M(P+1)+1 edges.
- R8: `pend_o[i]` is set one cycle after a rising `filt_o[i]` transition when `rise_en_i[i]`=1, and one cycle after a falling transition when `fall_en_i[i]`=1. A transition whose polarity is not enabled leaves the flag at 0.
- R9: A pulse on `clr_i[i]` clears `pend_o[i]` on the next edge, unless an enabled transition occurs at that same edge, in which case the flag stays set.
- R10: After reset, `filt_o` and `pend_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prescale_i | input | PRE_W | Shared prescaler setting P; tick period P+1 cycles |
| filt_en_i | input | N_LINES | Per-line filter enable |
| max_cnt_i | input | N_LINES*CNT_W | Per-line maximum count, line i in bits [i*CNT_W +: CNT_W] |
| rise_en_i | input | N_LINES | Per-line rising-edge pending enable |
| fall_en_i | input | N_LINES | Per-line falling-edge pending enable |
| clr_i | input | N_LINES | Write-1-to-clear strobe for pending flags |
| pad_i | input | N_LINES | Asynchronous external inputs |
| filt_o | output | N_LINES | Filtered levels |
| pend_o | output | N_LINES | Sticky pending flags |

## Verification
On every cycle, assertions check the following: the prescaler count stays in range and restarts after a setting change; a bypassed line copies its synchronised input; a filtered line changes level only on a tick; and a pending flag holds or clears as required, depending on the clear strobe and the edge. Only the bench scenarios can show the end-to-end latency numbers. These include the exact restart-aligned delay across a sweep of counts and prescaler settings, the suppression of short glitches, and the gating of pending flags by edge polarity.

// File: rtl/irq_filter_pkg.sv
package irq_filter_pkg;
  localparam int unsigned MIN_FILT_CNT = 3;

  function automatic logic is_bypass(input logic en, input logic [3:0] max_cnt);
    return !en || (max_cnt < 4'(MIN_FILT_CNT));
  endfunction
endpackage

// File: rtl/filt_prescaler.sv
module filt_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q, cnt_q;
  logic             chg;

  assign chg    = (div_i != div_q);
  assign tick_o = !chg && (cnt_q == div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (chg) begin
      div_q <= div_i;
      cnt_q <= '0;
    end else if (cnt_q == div_q) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: setting change restarts count
  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(chg) |-> (cnt_q == '0));
  // R2: count never passes the active setting
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg |-> (cnt_q <= div_q));
endmodule

// File: rtl/filt_line.sv
module filt_line
  import irq_filter_pkg::*;
#(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pad_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             tick_i,
  input  logic             rise_en_i,
  input  logic             fall_en_i,
  input  logic             clr_i,
  output logic             filt_o,
  output logic             pend_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_w, bypass;
  logic [CNT_W-1:0]       cnt_q;
  logic                   filt_q, prev_q, pend_q, edge_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pad_i};
  end
  assign sync_w = sync_q[SYNC_STAGES-1];
  assign bypass = is_bypass(en_i, 4'(max_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (bypass) begin
      filt_q <= sync_w;
      cnt_q  <= '0;
    end else if (sync_w == filt_q) begin
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (cnt_q + 1'b1 == max_i) begin
        filt_q <= sync_w;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign edge_w = (rise_en_i && filt_q && !prev_q) || (fall_en_i && !filt_q && prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= filt_q;
      pend_q <= (pend_q && !clr_i) || edge_w;
    end
  end

  assign filt_o = filt_q;
  assign pend_o = pend_q;

  // R3/R4: bypassed line copies synchronised input
  a_r4_bypass_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bypass) |-> (filt_q == $past(sync_w)));
  // R6: filtered line only moves on a tick
  a_r6_move_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(bypass) && !$past(tick_i)) |-> $stable(filt_q));
  // R9: pending flag held without clear
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_q) && !$past(clr_i)) |-> pend_q);
  // R9: clear wins only with no coincident edge
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_i) && !$past(edge_w)) |-> !pend_q);
  // R8: flag rises only after an enabled transition
  a_r8_set_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(prev_q != filt_q));
endmodule

// File: rtl/irq_filter_bank.sv
module irq_filter_bank #(
  parameter int unsigned N_LINES     = 4,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned PRE_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [PRE_W-1:0]         prescale_i,
  input  logic [N_LINES-1:0]       filt_en_i,
  input  logic [N_LINES*CNT_W-1:0] max_cnt_i,
  input  logic [N_LINES-1:0]       rise_en_i,
  input  logic [N_LINES-1:0]       fall_en_i,
  input  logic [N_LINES-1:0]       clr_i,
  input  logic [N_LINES-1:0]       pad_i,
  output logic [N_LINES-1:0]       filt_o,
  output logic [N_LINES-1:0]       pend_o
);
  logic tick;

  filt_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (prescale_i),
    .tick_o(tick)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    filt_line #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pad_i    (pad_i[i]),
      .en_i     (filt_en_i[i]),
      .max_i    (max_cnt_i[i*CNT_W +: CNT_W]),
      .tick_i   (tick),
      .rise_en_i(rise_en_i[i]),
      .fall_en_i(fall_en_i[i]),
      .clr_i    (clr_i[i]),
      .filt_o   (filt_o[i]),
      .pend_o   (pend_o[i])
    );
  end

  // R10: outputs clear right after reset release
  a_r10_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (filt_o == '0 && pend_o == '0));
endmodule

// File: tb/irq_filter_bank_bench.sv
module irq_filter_bank_bench;
  localparam int N = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    prescale = '0;
  logic [N-1:0]  en = '0, rise_en = '0, fall_en = '0, clr = '0, pad = '0;
  logic [N*CW-1:0] max_cnt = '0;
  logic [N-1:0]  filt, pend;
  int            tests = 0, fails = 0;

  always #4 clk = ~clk;

  irq_filter_bank u_irq_filter_bank (
    .clk_i(clk), .rst_ni(rst_n), .prescale_i(prescale), .filt_en_i(en),
    .max_cnt_i(max_cnt), .rise_en_i(rise_en), .fall_en_i(fall_en),
    .clr_i(clr), .pad_i(pad), .filt_o(filt), .pend_o(pend));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // toggle pad of a line at negedge, count edges until filt follows
  task automatic toggle_measure(input int ln, output int lat);
    logic want;
    want = ~pad[ln];
    pad[ln] = want;
    lat = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      lat++;
      if (filt[ln] == want) break;
    end
  endtask

  initial begin
    int lat;
    #200000000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat;
    cycles(3);
    check("R10 filt", int'(filt), 0);
    check("R10 pend", int'(pend), 0);
    rst_n = 1'b1;
    cycles(2);

    // R4: disabled line passes through regardless of count
    max_cnt[0 +: CW] = 4'd10;
    toggle_measure(0, lat); check("R4 R1 disabled rise", lat, 3);
    toggle_measure(0, lat); check("R4 R1 disabled fall", lat, 3);

    // R3: all-pass counts
    en[0] = 1'b1;
    for (int m = 0; m < 3; m++) begin
      max_cnt[0 +: CW] = 4'(m);
      cycles(2);
      toggle_measure(0, lat); check($sformatf("R3 allpass m=%0d", m), lat, 3);
    end
    if (pad[0]) begin toggle_measure(0, lat); end

    // R5/R7: restart-aligned exact latency sweep
    for (int p = 1; p <= 3; p++) begin
      for (int m = 3; m <= 15; m++) begin
        max_cnt[0 +: CW] = 4'(m);
        prescale = 4'd15;
        cycles(1);
        prescale = 4'(p);
        toggle_measure(0, lat);
        check($sformatf("R7 R2 exact p=%0d m=%0d", p, m), lat, m*(p+1)+1);
        check_rng($sformatf("R5 window p=%0d m=%0d", p, m), lat, (m-1)*(p+1)+3, m*(p+1)+2);
        cycles(2);
      end
    end

    // R5 with prescale 0: M+2
    prescale = 4'd0;
    for (int m = 3; m <= 15; m += 4) begin
      max_cnt[0 +: CW] = 4'(m);
      cycles(2);
      toggle_measure(0, lat); check($sformatf("R5 p=0 m=%0d", m), lat, m+2);
    end

    // R6: glitch of 4 cycles with M=6 is rejected
    max_cnt[0 +: CW] = 4'd6;
    cycles(3);
    begin
      logic lvl;
      lvl = filt[0];
      pad[0] = ~lvl;
      cycles(4);
      pad[0] = lvl;
      cycles(20);
      check("R6 glitch rejected", int'(filt[0]), int'(lvl));
      pad[0] = ~lvl;
      cycles(4);
      pad[0] = lvl;
      cycles(1);
      pad[0] = ~lvl;
      cycles(4);
      pad[0] = lvl;
      cycles(20);
      check("R6 counter clears between glitches", int'(filt[0]), int'(lvl));
    end

    // R8: rise-only on line 1 (bypass)
    rise_en[1] = 1'b1;
    pad[1] = 1'b1;
    cycles(3);
    check("R8 rise not yet", int'(pend[1]), 0);
    cycles(1);
    check("R8 rise pend", int'(pend[1]), 1);
    clr[1] = 1'b1; cycles(1); clr[1] = 1'b0;
    check("R9 clear", int'(pend[1]), 0);
    pad[1] = 1'b0;
    cycles(8);
    check("R8 fall ignored", int'(pend[1]), 0);

    // R8: fall-only on line 2
    fall_en[2] = 1'b1;
    pad[2] = 1'b1;
    cycles(8);
    check("R8 rise ignored", int'(pend[2]), 0);
    pad[2] = 1'b0;
    cycles(4);
    check("R8 fall pend", int'(pend[2]), 1);
    cycles(5);
    check("R9 sticky", int'(pend[2]), 1);

    // R9: clear coinciding with edge keeps flag
    rise_en[3] = 1'b1; fall_en[3] = 1'b1;
    pad[3] = 1'b1;
    cycles(4);
    check("R8 both rise", int'(pend[3]), 1);
    pad[3] = 1'b0;
    cycles(3);
    clr[3] = 1'b1; cycles(1); clr[3] = 1'b0;
    check("R9 edge beats clear", int'(pend[3]), 1);
    clr[3] = 1'b1; cycles(1); clr[3] = 1'b0;
    check("R9 clear alone", int'(pend[3]), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule